// File: doc/BRIEF.md
# Chained Block Cipher Sequencer

This block runs cipher-block-chaining encryption for a 16-bit bus. A 128-bit cipher engine sits outside it, reached through a start/done handshake. The block keeps one 128-bit chaining register. Software or DMA reaches that register through four ports:

- An XOR-only port folds an initialization vector into the register without starting a pass.
- An XOR-and-go port folds each plaintext word into the register. After the eighth word it launches the engine on the whole register.
- An output port returns the ciphertext one word at a time.
- A count port sets how many blocks a streamed run covers.

The engine result is written back into the chaining register. It is therefore both the ciphertext that is read out and the value the next block is XORed with.

For streaming, two level-sensitive request lines pace two DMA channels. One asks for the ciphertext to be read out. The other asks for the next plaintext block. A block counter ends the run and raises a done flag. A control word selects the mode. Only the CBC-encrypt setting XORs the data port. Any other setting loads plaintext words straight into the register.

Top module: `cbc_chain_ctl`

## Requirements
- R1: After rstN, or after a control write (address 0) with bit 15 set, the chaining register is zero, both word pointers are zero, no pass is in flight, and reqRead, reqWrite and runDone are low.
- R2: A write to address 1 XORs the data into the 16-bit register word at the input pointer and advances the pointer, wrapping after word 7. It never pulses engStart. Word 0 is bits 15:0 and word 7 is bits 127:112.
- R3: Control bits are: bit 0 chaining enable, bits 2:1 chaining mode, bits 4:3 operation. Only the value 1/01/00 (control word 16'h0003) selects CBC encryption. In that mode a write to address 2 XORs the data into the register word at the input pointer. In any other mode it replaces that word. After the eighth word, engStart is high for exactly one cycle in the next cycle, with engDataIn equal to the updated register.
- R4: On engDone during a pass, the register takes engDataOut and the output pointer returns to 0. busRData always shows the register word at the output pointer. While ciphertext is pending, each read strobe at address 4 advances the pointer. The eighth read ends the pending state.
- R5: reqRead is high during a run from the cycle after engDone, or after a count write that finds output pending, until the eighth output word has been read.
- R6: reqWrite is high while a run is active, blocks remain, no pass is in flight and no output is pending. It drops in the cycle after the eighth plaintext word is written.
- R7: A write to address 3 loads the block count and starts a run (a count of zero ends the run at once with runDone high). The count decrements on each eighth output read. When it reaches zero, both requests drop and runDone rises, and runDone stays high until the next count write or reset.
- R8: Writes to addresses 1 and 2 while a pass is in flight change neither the register nor the input pointer.
- R9: A soft reset in the same cycle as engDone takes priority: the engine result is discarded and the register reads zero.
- R10: A streamed run of blocks P1..Pn after a vector V yields C1 = E(V xor P1) and Ck = E(C(k-1) xor Pk).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 3 | Register address |
| busWData | input | 16 | Bus write data |
| busRData | output | 16 | Ciphertext word at the output pointer |
| engStart | output | 1 | One-cycle pulse that launches a cipher pass |
| engDataIn | output | 128 | Block presented to the engine |
| engDone | input | 1 | Engine result valid for one cycle |
| engDataOut | input | 128 | Engine result |
| reqRead | output | 1 | Level request: read ciphertext from address 4 |
| reqWrite | output | 1 | Level request: write plaintext to address 2 |
| runDone | output | 1 | Streamed run finished |

## Verification
The contested cycle is the one where the engine reports completion while the bus issues a soft reset through the control word. Both events want to write the chaining register and the pass-in-flight flag. The bench waits until its engine model has raised engDone for the current cycle and drives the reset write into that same clock edge. It then judges the outcome from the ports: busRData must read zero, reqRead must stay low, and a fresh block must encrypt against a zero chaining value.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int ADDR_W    = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IV   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_OUT  = 3'd4;

  // control word field encodings
  localparam logic [1:0] MODE_CBC = 2'b01;
  localparam logic [1:0] OP_ENC   = 2'b00;

  typedef struct packed {
    logic clrState;    // zero the chaining register
    logic xorWord;     // fold bus word into selected register word
    logic loadWord;    // replace selected register word
    logic captureOut;  // take the engine result
  } dpStrobe_t;
endpackage

// File: rtl/cbc_dpath.sv
module cbc_dpath
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 128,
  localparam int WORDS = BLK_W / DATA_W,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [PTR_W-1:0]  inPtr,
  input  logic [PTR_W-1:0]  outPtr,
  input  logic [DATA_W-1:0] busWData,
  input  logic [BLK_W-1:0]  engDataOut,
  output logic [BLK_W-1:0]  stateBlk,
  output logic [DATA_W-1:0] busRData
);
  logic [WORDS-1:0][DATA_W-1:0] stateQ;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = (inPtr == PTR_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stateQ[w] <= '0;
      end else if (strobe.clrState) begin
        stateQ[w] <= '0;
      end else if (strobe.captureOut) begin
        stateQ[w] <= engDataOut[w*DATA_W +: DATA_W];
      end else if (strobe.xorWord && hit) begin
        stateQ[w] <= stateQ[w] ^ busWData;
      end else if (strobe.loadWord && hit) begin
        stateQ[w] <= busWData;
      end
    end
  end

  assign stateBlk = stateQ;
  assign busRData = stateQ[outPtr];
endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 128,
  parameter int CNT_W  = 16,
  localparam int WORDS = BLK_W / DATA_W,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              engDone,
  output dpStrobe_t         strobe,
  output logic [PTR_W-1:0]  inPtr,
  output logic [PTR_W-1:0]  outPtr,
  output logic              engStart,
  output logic              reqRead,
  output logic              reqWrite,
  output logic              runDone
);
  localparam logic [PTR_W-1:0] LAST_WORD = PTR_W'(WORDS - 1);

  logic             chainEn;
  logic [1:0]       modeF;
  logic [1:0]       opF;
  logic             busy;
  logic             outReady;
  logic             running;
  logic             startQ;
  logic [CNT_W-1:0] blkCnt;

  logic wrCtrl, softRst, wrIv, wrData, wrCnt, rdOut, cbcSel, lastIn, lastOut;
  logic [CNT_W-1:0] cntVal;

  assign wrCtrl  = busWrEn && (busAddr == ADDR_CTRL);
  assign softRst = wrCtrl && busWData[DATA_W-1];
  assign wrIv    = busWrEn && (busAddr == ADDR_IV) && !busy;
  assign wrData  = busWrEn && (busAddr == ADDR_DATA) && !busy;
  assign wrCnt   = busWrEn && (busAddr == ADDR_CNT);
  assign rdOut   = busRdEn && (busAddr == ADDR_OUT) && outReady;
  assign cbcSel  = chainEn && (modeF == MODE_CBC) && (opF == OP_ENC);
  assign lastIn  = (inPtr == LAST_WORD);
  assign lastOut = (outPtr == LAST_WORD);
  assign cntVal  = busWData[CNT_W-1:0];

  always_comb begin
    strobe.clrState   = softRst;
    strobe.xorWord    = wrIv || (wrData && cbcSel);
    strobe.loadWord   = wrData && !cbcSel;
    strobe.captureOut = engDone && busy && !softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainEn  <= 1'b0;
      modeF    <= '0;
      opF      <= '0;
      inPtr    <= '0;
      outPtr   <= '0;
      busy     <= 1'b0;
      outReady <= 1'b0;
      running  <= 1'b0;
      runDone  <= 1'b0;
      blkCnt   <= '0;
      startQ   <= 1'b0;
    end else begin
      startQ <= 1'b0;
      if (wrCtrl) begin
        chainEn <= busWData[0];
        modeF   <= busWData[2:1];
        opF     <= busWData[4:3];
      end
      if (softRst) begin
        inPtr    <= '0;
        outPtr   <= '0;
        busy     <= 1'b0;
        outReady <= 1'b0;
        running  <= 1'b0;
        runDone  <= 1'b0;
        blkCnt   <= '0;
      end else begin
        if (wrIv || wrData) begin
          inPtr <= lastIn ? '0 : inPtr + 1'b1;
        end
        if (wrData && lastIn) begin
          busy   <= 1'b1;
          startQ <= 1'b1;
        end
        if (rdOut) begin
          if (lastOut) begin
            outReady <= 1'b0;
            outPtr   <= '0;
            if (running) begin
              if (blkCnt == CNT_W'(1)) begin
                running <= 1'b0;
                runDone <= 1'b1;
                blkCnt  <= '0;
              end else begin
                blkCnt <= blkCnt - 1'b1;
              end
            end
          end else begin
            outPtr <= outPtr + 1'b1;
          end
        end
        if (strobe.captureOut) begin
          busy     <= 1'b0;
          outReady <= 1'b1;
          outPtr   <= '0;
        end
        if (wrCnt) begin
          blkCnt  <= cntVal;
          running <= (cntVal != '0);
          runDone <= (cntVal == '0);
        end
      end
    end
  end

  assign engStart = startQ;
  assign reqRead  = running && outReady;
  assign reqWrite = running && !busy && !outReady && (blkCnt != '0);
endmodule

// File: rtl/cbc_chain_ctl.sv
module cbc_chain_ctl
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 128,
  parameter int CNT_W  = 16,
  localparam int WORDS = BLK_W / DATA_W,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              engStart,
  output logic [BLK_W-1:0]  engDataIn,
  input  logic              engDone,
  input  logic [BLK_W-1:0]  engDataOut,
  output logic              reqRead,
  output logic              reqWrite,
  output logic              runDone
);
  dpStrobe_t        strobe;
  logic [PTR_W-1:0] inPtr;
  logic [PTR_W-1:0] outPtr;

  cbc_ctrl #(.DATA_W(DATA_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWData(busWData), .engDone(engDone),
    .strobe(strobe), .inPtr(inPtr), .outPtr(outPtr), .engStart(engStart),
    .reqRead(reqRead), .reqWrite(reqWrite), .runDone(runDone)
  );

  cbc_dpath #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inPtr(inPtr), .outPtr(outPtr),
    .busWData(busWData), .engDataOut(engDataOut),
    .stateBlk(engDataIn), .busRData(busRData)
  );
endmodule

// File: rtl/cbc_chain_chk.sv
module cbc_chain_chk
  import cbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWData,
  input logic [DATA_W-1:0] busRData,
  input logic              engStart,
  input logic [BLK_W-1:0]  engDataIn,
  input logic              engDone,
  input logic [BLK_W-1:0]  engDataOut,
  input logic              reqRead,
  input logic              reqWrite,
  input logic              runDone
);
  logic swRst, ivWr, cntWr;
  assign swRst = busWrEn && (busAddr == ADDR_CTRL) && busWData[DATA_W-1];
  assign ivWr  = busWrEn && (busAddr == ADDR_IV);
  assign cntWr = busWrEn && (busAddr == ADDR_CNT);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (!reqRead && !reqWrite && !runDone));

  assert_iv_no_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    ivWr |=> !engStart);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  assert_read_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqRead) |-> ($past(engDone) || $past(cntWr)));

  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(reqRead && reqWrite));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> (!reqRead && !reqWrite));
endmodule

bind cbc_chain_ctl cbc_chain_chk #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/sim_cbc_chain_ctl.sv
module sim_cbc_chain_ctl;
  import cbc_pkg::*;

  localparam int DW = 16;
  localparam int BW = 128;
  localparam int NW = BW / DW;
  localparam logic [BW-1:0] KEYMIX = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  localparam logic [BW-1:0] IV_VAL = 128'h00112233445566778899aabbccddeeff;
  localparam int NBLK = 4;
  localparam logic [BW-1:0] PT_TAB [0:NBLK-1] = '{
    128'h6bc1bee22e409f96e93d7e117393172a,
    128'hae2d8a571e03ac9c9eb76fac45af8e51,
    128'h30c81c46a35ce411e5fbc1191a0a52ef,
    128'hf69f2445df4f9b17ad2b417be66c3710
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DW-1:0] busWData = '0;
  logic [DW-1:0] busRData;
  logic engStart, engDone = 1'b0;
  logic [BW-1:0] engDataIn, engDataOut = '0;
  logic reqRead, reqWrite, runDone;

  int errors = 0, checks = 0, startSeen = 0;

  always #5 clk = ~clk;

  cbc_chain_ctl u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .engStart(engStart), .engDataIn(engDataIn), .engDone(engDone),
    .engDataOut(engDataOut), .reqRead(reqRead), .reqWrite(reqWrite),
    .runDone(runDone)
  );

  function automatic logic [BW-1:0] engF(input logic [BW-1:0] x);
    return {x[95:0], x[127:96]} ^ KEYMIX;
  endfunction

  // engine stand-in: three-cycle latency, one-cycle done pulse
  logic [BW-1:0] engCap = '0;
  int engCnt = 0;
  always @(negedge clk) begin
    if (engDone) engDone = 1'b0;
    if (engCnt != 0) begin
      engCnt = engCnt - 1;
      if (engCnt == 0) begin
        engDone = 1'b1;
        engDataOut = engF(engCap);
      end
    end
    if (engStart) begin
      startSeen = startSeen + 1;
      engCap = engDataIn;
      engCnt = 3;
    end
  end

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(output logic [DW-1:0] d);
    @(negedge clk);
    d = busRData;
    busRdEn = 1'b1; busAddr = ADDR_OUT;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic writeBlock(input logic [ADDR_W-1:0] a, input logic [BW-1:0] blk);
    for (int i = 0; i < NW; i++) busWrite(a, blk[i*DW +: DW]);
  endtask

  task automatic readBlock(output logic [BW-1:0] blk);
    logic [DW-1:0] w;
    blk = '0;
    for (int i = 0; i < NW; i++) begin
      busRead(w);
      blk[i*DW +: DW] = w;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [BW-1:0] got, chain, expBlk;
    logic [DW-1:0] w;
    int s0;

    repeat (3) @(negedge clk);
    // R1: state after reset
    chk("R1 reqRead", BW'(reqRead), '0);
    chk("R1 reqWrite", BW'(reqWrite), '0);
    chk("R1 runDone", BW'(runDone), '0);
    chk("R1 busRData", BW'(busRData), '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 engStart", BW'(engStart), '0);

    // R2: vector load through XOR-only port
    busWrite(ADDR_CTRL, 16'h8003);
    s0 = startSeen;
    writeBlock(ADDR_IV, IV_VAL);
    repeat (5) @(negedge clk);
    chk("R2 no pass started", BW'(startSeen - s0), '0);
    chk("R2 word0 visible", BW'(busRData), BW'(IV_VAL[15:0]));

    // R7/R5/R6/R10: streamed run walking the vector table
    busWrite(ADDR_CNT, 16'(NBLK));
    chk("R7 reqWrite after count write", BW'(reqWrite), 1);
    chain = IV_VAL;
    for (int b = 0; b < NBLK; b++) begin
      while (!reqWrite) @(negedge clk);
      writeBlock(ADDR_DATA, PT_TAB[b]);
      chk("R6 reqWrite drops after 8th word", BW'(reqWrite), '0);
      while (!reqRead) @(negedge clk);
      got = '0;
      for (int i = 0; i < NW - 1; i++) begin
        busRead(w);
        got[i*DW +: DW] = w;
      end
      chk("R5 reqRead held before last word", BW'(reqRead), 1);
      busRead(w);
      got[(NW-1)*DW +: DW] = w;
      chk("R5 reqRead drops after 8th read", BW'(reqRead), '0);
      expBlk = engF(chain ^ PT_TAB[b]);
      chk("R10 chained ciphertext", got, expBlk);
      chain = expBlk;
    end
    chk("R7 runDone at zero count", BW'(runDone), 1);
    chk("R7 requests idle", BW'({reqRead, reqWrite}), '0);

    // R3 + R8: non-CBC mode replaces; write during a pass ignored
    busWrite(ADDR_CTRL, 16'h0005);
    writeBlock(ADDR_DATA, PT_TAB[0]);
    busWrite(ADDR_DATA, 16'hffff);
    repeat (6) @(negedge clk);
    readBlock(got);
    chk("R3 non-chained mode loads", got, engF(PT_TAB[0]));
    chain = got;
    busWrite(ADDR_CTRL, 16'h0003);
    s0 = startSeen;
    writeBlock(ADDR_DATA, PT_TAB[1]);
    @(negedge clk);
    chk("R3 single start pulse", BW'(startSeen - s0), 1);
    repeat (6) @(negedge clk);
    readBlock(got);
    chk("R8 busy write ignored, R4 chain", got, engF(chain ^ PT_TAB[1]));

    // R9: soft reset in the same cycle as engDone
    writeBlock(ADDR_DATA, PT_TAB[2]);
    forever begin
      @(negedge clk); #1;
      if (engDone) break;
    end
    busWrEn = 1'b1; busAddr = ADDR_CTRL; busWData = 16'h8003;
    @(negedge clk);
    busWrEn = 1'b0;
    chk("R9 result discarded", BW'(busRData), '0);
    chk("R9 reqRead low", BW'(reqRead), '0);
    chk("R1 runDone cleared by soft reset", BW'(runDone), '0);
    writeBlock(ADDR_DATA, PT_TAB[3]);
    repeat (6) @(negedge clk);
    readBlock(got);
    chk("R9 chain restarts from zero", got, engF(PT_TAB[3]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule